// File: doc/BRIEF.md
# Asynchronous Page-Mode PSRAM Controller

This block sits between a synchronous user port and a 16-bit pseudo-static RAM that is driven only through its asynchronous access modes. It accepts one request at a time: a single-word read, a four-word page read or a single-word write with a byte mask. It then sequences the chip select, output enable, write enable and byte-lane strobes, timing each phase with one internal counter whose limits are parameters given in controller clock cycles.

In a page read the upper address bits stay fixed and only the two lowest bits advance. The first word therefore costs a full read period and each later word a shorter page period. Each word is captured on the last cycle of its period and handed back with a one-cycle valid pulse. The memory's synchronous-mode pins are parked (clock low, address-valid high, mode-register-select high), and its wait output is not used.

Top module: `psram_async_ctrl`

## Requirements
- R1: While reset is low and after it, until a request is taken, all memory strobes (mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_mrs_n) are high, mem_dq_oe is low, rd_valid is low and req_ready is high.
- R2: Whenever mem_oe_n is low, mem_cs_n is low, mem_we_n and mem_mrs_n are high, both byte lanes are enabled, and mem_dq_oe is low.
- R3: A request with req_kind 2'b00 (single read), or 2'b11 (treated the same), holds the read strobes for RD_CYC cycles with mem_addr equal to req_addr. The word on mem_dq_in in the last of those cycles appears on rd_data with rd_valid high for exactly one cycle, in the cycle after.
- R4: A request with req_kind 2'b01 (page read) performs four word periods. The first lasts RD_CYC cycles and the others PG_CYC cycles each. Bits 21..2 of mem_addr stay equal to req_addr, and bits 1..0 start at req_addr[1:0] and increase by one per word, wrapping modulo 4. One rd_valid pulse is given per word, carrying the word sampled on that word's last cycle.
- R5: A request with req_kind 2'b10 (write) and a non-zero req_be holds mem_cs_n and mem_we_n low for WR_CYC cycles, with mem_oe_n high and mem_dq_out equal to req_wdata. mem_ub_n is the inverse of req_be[1] and mem_lb_n is the inverse of req_be[0].
- R6: mem_dq_oe is high only while mem_we_n is low; at all other times the data bus is released.
- R7: After every access, at least one cycle with mem_cs_n, mem_oe_n and mem_we_n all high follows before the next access.
- R8: req_ready is high only while no access is in progress. A request is taken on a clock edge where req_valid and req_ready are both high, and a request held during a busy period is taken only when the block is idle again.
- R9: mem_clk is always low, and mem_adv_n and mem_mrs_n are always high.
- R10: A write request with req_be equal to 2'b00 is taken but produces no strobe activity, and req_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_kind | input | 2 | 00 single read, 01 page read, 10 write, 11 single read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 2 | Write byte mask, bit 1 upper, bit 0 lower |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse per returned read word |
| rd_data | output | DATA_W | Captured read word |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_mrs_n | output | 1 | Mode-register select, held high |
| mem_clk | output | 1 | Memory clock, held low |
| mem_adv_n | output | 1 | Address-valid strobe, held high |
| mem_dq_out | output | DATA_W | Data driven to the pad |
| mem_dq_oe | output | 1 | Pad output enable for the data bus |
| mem_dq_in | input | DATA_W | Data from the pad |

## Verification
The bench builds the controller with RD_CYC=5, PG_CYC=1 and WR_CYC=2. A page period of one cycle makes every cycle of words two to four a capture cycle, so the rd_valid pulses arrive back to back and each must carry a different address-derived word. The short write pulse and the longer first read period also keep the gap and handshake timing distinguishable. A memory model returns a word computed from the address the controller actually drives, so a wrong page step or a wrong wrap shows up as wrong data as well as a wrong address.

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int RD_CYC = 6,
  parameter int PG_CYC = 3,
  parameter int WR_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic              mem_mrs_n,
  output logic              mem_clk,
  output logic              mem_adv_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int MAX_CYC = (RD_CYC > PG_CYC) ? ((RD_CYC > WR_CYC) ? RD_CYC : WR_CYC)
                                             : ((PG_CYC > WR_CYC) ? PG_CYC : WR_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_GAP} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        words;
  logic              page_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wdata_q;

  logic [CNT_W-1:0]  rd_lim;
  logic              more_words;

  assign rd_lim     = (words == 2'd0) ? CNT_W'(RD_CYC - 1) : CNT_W'(PG_CYC - 1);
  assign more_words = page_q && (words != 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      words    <= '0;
      page_q   <= 1'b0;
      addr_q   <= '0;
      be_q     <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          cnt   <= '0;
          words <= '0;
          if (req_valid) begin
            if (req_kind == 2'b10) begin
              if (req_be != 2'b00) begin
                state   <= S_WRITE;
                addr_q  <= req_addr;
                be_q    <= req_be;
                wdata_q <= req_wdata;
              end
            end else begin
              state  <= S_READ;
              addr_q <= req_addr;
              page_q <= (req_kind == 2'b01);
            end
          end
        end
        S_READ: begin
          if (cnt == rd_lim) begin
            rd_data  <= mem_dq_in;
            rd_valid <= 1'b1;
            cnt      <= '0;
            if (more_words) begin
              words       <= words + 2'd1;
              addr_q[1:0] <= addr_q[1:0] + 2'd1;
            end else begin
              state <= S_GAP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WRITE: begin
          if (cnt == CNT_W'(WR_CYC - 1)) begin
            state <= S_GAP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign mem_addr   = addr_q;
  assign mem_cs_n   = !(state == S_READ || state == S_WRITE);
  assign mem_oe_n   = !(state == S_READ);
  assign mem_we_n   = !(state == S_WRITE);
  assign mem_ub_n   = (state == S_READ) ? 1'b0 : (state == S_WRITE) ? !be_q[1] : 1'b1;
  assign mem_lb_n   = (state == S_READ) ? 1'b0 : (state == S_WRITE) ? !be_q[0] : 1'b1;
  assign mem_mrs_n  = 1'b1;
  assign mem_clk    = 1'b0;
  assign mem_adv_n  = 1'b1;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (state == S_WRITE);
endmodule

// File: rtl/psram_async_ctrl_chk.sv
module psram_async_ctrl_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic              mem_mrs_n,
  input logic              mem_dq_oe
);
  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n && mem_mrs_n && !mem_ub_n && !mem_lb_n && !mem_dq_oe)); // R2

  AST_PAGE_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr[ADDR_W-1:2])); // R4

  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_mrs_n && (!mem_ub_n || !mem_lb_n))); // R5

  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n); // R6

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |=> (mem_cs_n && mem_oe_n && mem_we_n)); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n)); // R8

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n)); // R3
endmodule

bind psram_async_ctrl psram_async_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_mrs_n(mem_mrs_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_psram_async_ctrl.sv
module test_psram_async_ctrl;
  localparam int RD = 5;
  localparam int PG = 1;
  localparam int WR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b00;
  logic [21:0] req_addr = '0;
  logic [1:0]  req_be = 2'b00;
  logic [15:0] req_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [21:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_mrs_n;
  logic        mem_clk, mem_adv_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  always #10 clk = ~clk;

  function automatic logic [15:0] mdata(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], a[21:12]} ^ 16'h3C5A;
  endfunction

  assign mem_dq_in = mdata(mem_addr);

  psram_async_ctrl #(.ADDR_W(22), .DATA_W(16), .RD_CYC(RD), .PG_CYC(PG), .WR_CYC(WR)) i_psram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_mrs_n(mem_mrs_n),
    .mem_clk(mem_clk), .mem_adv_n(mem_adv_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  typedef struct {
    bit          cs, oe, we, ub, lb, dqoe, ready, chk_addr, rdv;
    logic [21:0] addr;
    logic [15:0] rdata;
    logic [15:0] wdata;
    string       tag;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    errors = 0;
  bit    cur_ready = 1'b1;
  bit    done = 1'b0;
  string idle_tag = "R1";

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic exp_t idle_e();
    exp_t e;
    e.cs = 1; e.oe = 1; e.we = 1; e.ub = 1; e.lb = 1; e.dqoe = 0;
    e.ready = 1; e.chk_addr = 0; e.rdv = 0;
    e.addr = '0; e.rdata = '0; e.wdata = '0; e.tag = idle_tag;
    return e;
  endfunction

  task automatic check_cycle();
    exp_t e;
    @(negedge clk);
    if (q.size() != 0) e = q.pop_front();
    else e = idle_e();
    cmp(e.tag, "mem_cs_n", 32'(mem_cs_n), 32'(e.cs));
    cmp(e.tag, "mem_oe_n", 32'(mem_oe_n), 32'(e.oe));
    cmp(e.tag, "mem_we_n", 32'(mem_we_n), 32'(e.we));
    cmp(e.tag, "mem_ub_n", 32'(mem_ub_n), 32'(e.ub));
    cmp(e.tag, "mem_lb_n", 32'(mem_lb_n), 32'(e.lb));
    cmp("R6", "mem_dq_oe", 32'(mem_dq_oe), 32'(e.dqoe));
    cmp("R8", "req_ready", 32'(req_ready), 32'(e.ready));
    cmp(e.tag, "rd_valid", 32'(rd_valid), 32'(e.rdv));
    if (e.rdv) cmp(e.tag, "rd_data", 32'(rd_data), 32'(e.rdata));
    if (e.chk_addr) cmp(e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
    if (e.dqoe) cmp("R5", "mem_dq_out", 32'(mem_dq_out), 32'(e.wdata));
    cmp("R9", "mem_clk", 32'(mem_clk), 32'd0);
    cmp("R9", "mem_adv_n", 32'(mem_adv_n), 32'd1);
    cmp("R9", "mem_mrs_n", 32'(mem_mrs_n), 32'd1);
    cur_ready = e.ready;
  endtask

  task automatic issue(input logic [1:0] kind, input logic [21:0] addr, input logic [1:0] be,
                       input logic [15:0] wdata, input string tag);
    exp_t e;
    logic [21:0] prev;
    req_kind = kind; req_addr = addr; req_be = be; req_wdata = wdata; req_valid = 1'b1;
    while (!cur_ready) check_cycle();
    prev = addr;
    if (kind == 2'b10) begin
      if (be == 2'b00) begin
        e = idle_e(); e.tag = "R10";
        q.push_back(e);
      end else begin
        for (int c = 0; c < WR; c++) begin
          e = idle_e();
          e.cs = 0; e.we = 0; e.ub = !be[1]; e.lb = !be[0]; e.dqoe = 1; e.ready = 0;
          e.chk_addr = 1; e.addr = addr; e.wdata = wdata; e.tag = tag;
          q.push_back(e);
        end
        e = idle_e(); e.ready = 0; e.tag = "R7";
        q.push_back(e);
      end
    end else begin
      for (int w = 0; w < ((kind == 2'b01) ? 4 : 1); w++) begin
        logic [1:0]  lo;
        logic [21:0] a;
        lo = addr[1:0] + 2'(w);
        a  = {addr[21:2], lo};
        for (int c = 0; c < ((w == 0) ? RD : PG); c++) begin
          e = idle_e();
          e.cs = 0; e.oe = 0; e.ub = 0; e.lb = 0; e.ready = 0;
          e.chk_addr = 1; e.addr = a; e.tag = tag;
          if (c == 0 && w > 0) begin e.rdv = 1; e.rdata = mdata(prev); end
          q.push_back(e);
        end
        prev = a;
      end
      e = idle_e(); e.ready = 0; e.rdv = 1; e.rdata = mdata(prev); e.tag = tag;
      q.push_back(e);
    end
    check_cycle();
    req_valid = 1'b0; req_kind = 2'b01; req_addr = 22'h3FFFFF; req_be = 2'b11; req_wdata = 16'hDEAD;
  endtask

  initial begin
    repeat (3) check_cycle();          // R1 reset state
    rst_n = 1'b1;
    repeat (2) check_cycle();          // R1 idle after reset
    idle_tag = "R8";
    issue(2'b00, 22'h12345, 2'b00, 16'h0, "R3");
    issue(2'b01, 22'h2A5F0, 2'b00, 16'h0, "R4");
    issue(2'b01, 22'h00C02, 2'b00, 16'h0, "R4");   // wraps 2,3,0,1
    issue(2'b10, 22'h15555, 2'b11, 16'hA1B2, "R5");
    issue(2'b10, 22'h0AAAA, 2'b01, 16'h1357, "R5");
    issue(2'b10, 22'h3F00F, 2'b10, 16'h9BDF, "R5");
    issue(2'b10, 22'h01234, 2'b00, 16'hFFFF, "R10");
    repeat (2) check_cycle();          // R10 nothing happened
    issue(2'b11, 22'h3FFFF, 2'b00, 16'h0, "R3");
    issue(2'b01, 22'h3FFFF, 2'b00, 16'h0, "R4");   // R8 held request taken only when idle
    issue(2'b10, 22'h20001, 2'b11, 16'h4242, "R5");
    issue(2'b00, 22'h20001, 2'b00, 16'h0, "R3");
    repeat (6) check_cycle();          // R7 gap and idle
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule